// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block sits between a local bus and a PCI master and turns each local address into a PCI address. It does this through a small set of programmable windows. Each window has two registers. The base register gives the local region: a 1 MB aligned base, a power-of-two size code and an enable bit. The map register gives the PCI-side base and the cycle type. When windows overlap, the window with the lowest index wins. This lets software widen window 0 so that it covers window 1. Window 1 can then be reprogrammed as a 16 MB configuration aperture without disturbing the memory mapping.

In configuration mode the map register also decides what happens to PCI address bits 1:0. They are either forced to 00 (type 0 cycles) or passed through from the local address (type 1 cycles). For type 0 cycles, the high map bits supply the one-hot device select lines above bit 23. The last window always produces I/O cycles.

A lock protects the window registers. It is set at reset. A key word clears it, and setting the lock bit sets it again. Every request is answered exactly one clock later with a registered result.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset the lock is set, all windows are disabled, and `res_valid` is 0. A request in this state misses.
- R2: `res_valid` rises exactly one cycle after `req_valid`, and is 0 in the cycle after a cycle with no request.
- R3: Base register layout: bits 31:20 hold the local base, bits 4:1 hold size code c, and bit 0 is the enable.
  - The window spans 2^(20+c) bytes. A code above 11 acts as 11.
  - The window is aligned down to its own size, so base bits below the size are ignored.
  - An address inside the window hits, and an address one byte outside it does not.
  - A window whose enable bit is clear never hits.
- R4: When several enabled windows hit, `res_win` is the lowest index among them.
- R5: Map register layout: bits 15:4 hold PCI address bits 31:20. The translated address is that base plus the request's offset inside the window, modulo 2^32.
- R6: A request that hits no window gives `res_hit`=0, `res_win`=0, `res_addr`=0, `res_type`=0 and `res_cfg_lo`=0.
- R7: Cycle type comes from map bits 3:1: 3'b011 memory, 3'b110 multiple memory, 3'b101 configuration. The highest-numbered window always reports I/O (3'b000), whatever its map type field holds.
- R8: In a configuration cycle, map bit 0 = 0 forces address bits 1:0 to 00, and map bit 0 = 1 passes them from the request. `res_cfg_lo` equals those two bits for configuration cycles and is 00 otherwise.
- R9: Write port: `wr_sel` = {kind[1:0], index[1:0]}, where kind 0 is base, 1 is map and 2 is the lock register.
  - While locked, base and map writes are ignored.
  - While locked, a lock-register write of 0xA05F in data bits 15:0 unlocks, and any other lock-register write is ignored.
  - While unlocked, a lock-register write with data bit 14 set locks again.
- R10: A register write affects the requests presented after its write cycle. A request presented in the same cycle as a write uses the old settings.
- R11: A 16 MB configuration window passes type 0 device-select bits through its map base bits 31:24, and passes the type 1 fields (bus 23:16, device 15:11, function 10:8, register 7:2) from the local offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select {kind, window index} |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Local-bus address |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Some enabled window matched |
| res_win | output | 2 | Index of the winning window |
| res_addr | output | 32 | Translated PCI address |
| res_type | output | 3 | Cycle type of the winning window |
| res_cfg_lo | output | 2 | Address bits 1:0 for configuration cycles |

## Verification
A request presented at one rising edge is translated from the register state of that edge and is on the result ports just after that same edge. The bench therefore drives each request on a falling edge and compares all result fields on the next falling edge, half a cycle after capture. A register write is applied to the bench's own model only after the expected value of any request in the same cycle has been computed. This is how the bench checks that the old settings apply in that cycle. After each request is withdrawn, the bench checks one further falling edge to confirm that `res_valid` has dropped.

// File: rtl/awt_pkg.sv
package awt_pkg;
   localparam logic [2:0] CYC_IO   = 3'b000;
   localparam logic [2:0] CYC_MEM  = 3'b011;
   localparam logic [2:0] CYC_MEMX = 3'b110;
   localparam logic [2:0] CYC_CFG  = 3'b101;

   localparam logic [1:0] KIND_BASE = 2'd0;
   localparam logic [1:0] KIND_MAP  = 2'd1;
   localparam logic [1:0] KIND_LOCK = 2'd2;

   localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
   localparam int          LOCK_BIT   = 14;
endpackage

// File: rtl/awt_regs.sv
module awt_regs
   import awt_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 32,
   parameter int MAP_W   = 16,
   parameter int IDX_W   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W+1:0]                wr_sel,
   input  logic [ADDR_W-1:0]               wr_data,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_q,
   output logic [NUM_WIN-1:0][MAP_W-1:0]   map_q,
   output logic                            lock_q
);
   logic [1:0]       wr_kind;
   logic [IDX_W-1:0] wr_idx;
   assign wr_kind = wr_sel[IDX_W+1:IDX_W];
   assign wr_idx  = wr_sel[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         map_q  <= '0;
      end else if (wr_en && !lock_q) begin
         for (int i = 0; i < NUM_WIN; i++) begin
            if (wr_idx == IDX_W'(i)) begin
               if (wr_kind == KIND_BASE) base_q[i] <= wr_data;
               else if (wr_kind == KIND_MAP) map_q[i] <= wr_data[MAP_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b1;
      end else if (wr_en && wr_kind == KIND_LOCK) begin
         if (lock_q) begin
            if (wr_data[15:0] == UNLOCK_KEY) lock_q <= 1'b0;
         end else if (wr_data[LOCK_BIT]) begin
            lock_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/awt_window.sv
module awt_window
   import awt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int GRAIN_W  = 20,
   parameter int SZ_W     = 4,
   parameter int MAP_W    = 16,
   parameter bit FORCE_IO = 1'b0
) (
   input  logic [ADDR_W-1:0] base_reg,
   input  logic [MAP_W-1:0]  map_reg,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr,
   output logic [2:0]        xtype
);
   localparam int MAX_CODE = ADDR_W - GRAIN_W - 1;

   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] win_base;
   logic [ADDR_W-1:0] sum;
   logic              unused_bits;

   always_comb begin
      int sh;
      sh = GRAIN_W + ((int'(base_reg[SZ_W:1]) > MAX_CODE) ? MAX_CODE : int'(base_reg[SZ_W:1]));
      mask = {ADDR_W{1'b1}} << sh;
   end

   assign win_base = {base_reg[ADDR_W-1:GRAIN_W], {GRAIN_W{1'b0}}};
   assign hit      = base_reg[0] && ((addr & mask) == (win_base & mask));
   assign sum      = {map_reg[MAP_W-1:4], {GRAIN_W{1'b0}}} + (addr & ~mask);

   generate
      if (FORCE_IO) begin : g_io
         assign xtype = CYC_IO;
      end else begin : g_typed
         assign xtype = map_reg[3:1];
      end
   endgenerate

   assign xaddr = (xtype == CYC_CFG && !map_reg[0]) ? {sum[ADDR_W-1:2], 2'b00} : sum;
   assign unused_bits = ^{base_reg[GRAIN_W-1:SZ_W+1], map_reg[3:1]};
endmodule

// File: rtl/awt_pick.sv
module awt_pick #(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_WIN-1:0]              hits,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xaddr,
   input  logic [NUM_WIN-1:0][2:0]         xtype,
   output logic                            any,
   output logic [IDX_W-1:0]                idx,
   output logic [ADDR_W-1:0]               addr,
   output logic [2:0]                      ctype
);
   always_comb begin
      any   = 1'b0;
      idx   = '0;
      addr  = '0;
      ctype = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any   = 1'b1;
            idx   = IDX_W'(i);
            addr  = xaddr[i];
            ctype = xtype[i];
         end
      end
   end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
   import awt_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 32,
   parameter int GRAIN_W = 20,
   parameter int SZ_W    = 4,
   localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int SEL_W  = IDX_W + 2,
   localparam int MAP_W  = ADDR_W - GRAIN_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_win,
   output logic [ADDR_W-1:0] res_addr,
   output logic [2:0]        res_type,
   output logic [1:0]        res_cfg_lo
);
   generate
      if (NUM_WIN < 1) begin : g_bad_win
         $error("NUM_WIN must be at least 1");
      end
      if (ADDR_W < 16 || GRAIN_W + 2 > ADDR_W) begin : g_bad_addr
         $error("ADDR_W must be >= 16 and exceed GRAIN_W by 2");
      end
      if (SZ_W + 1 > GRAIN_W || (1 << SZ_W) - 1 < ADDR_W - GRAIN_W - 1) begin : g_bad_sz
         $error("SZ_W must fit below GRAIN_W and cover all sizes");
      end
   endgenerate

   logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
   logic [NUM_WIN-1:0][MAP_W-1:0]  map_q;
   logic                           lock_q;
   logic [NUM_WIN-1:0]             hits;
   logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr;
   logic [NUM_WIN-1:0][2:0]        xtype;
   logic                           p_hit;
   logic [IDX_W-1:0]               p_idx;
   logic [ADDR_W-1:0]              p_addr;
   logic [2:0]                     p_type;

   awt_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MAP_W(MAP_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .base_q(base_q), .map_q(map_q), .lock_q(lock_q)
   );

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         awt_window #(
            .ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W), .SZ_W(SZ_W), .MAP_W(MAP_W),
            .FORCE_IO(w == NUM_WIN - 1)
         ) u_win (
            .base_reg(base_q[w]), .map_reg(map_q[w]), .addr(req_addr),
            .hit(hits[w]), .xaddr(xaddr[w]), .xtype(xtype[w])
         );
      end
   endgenerate

   awt_pick #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
      .hits(hits), .xaddr(xaddr), .xtype(xtype),
      .any(p_hit), .idx(p_idx), .addr(p_addr), .ctype(p_type)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_win    <= '0;
         res_addr   <= '0;
         res_type   <= '0;
         res_cfg_lo <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_hit    <= p_hit;
            res_win    <= p_idx;
            res_addr   <= p_addr;
            res_type   <= p_type;
            res_cfg_lo <= (p_type == CYC_CFG) ? p_addr[1:0] : 2'b00;
         end
      end
   end
endmodule

// File: rtl/awt_checker.sv
module awt_checker
   import awt_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 32,
   parameter int MAP_W   = 16,
   parameter int IDX_W   = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [IDX_W+1:0]               wr_sel,
   input logic [ADDR_W-1:0]              wr_data,
   input logic                           req_valid,
   input logic                           res_valid,
   input logic                           res_hit,
   input logic [IDX_W-1:0]               res_win,
   input logic [ADDR_W-1:0]              res_addr,
   input logic [2:0]                     res_type,
   input logic [1:0]                     res_cfg_lo,
   input logic                           locked,
   input logic [NUM_WIN-1:0][ADDR_W-1:0] base_flat,
   input logic [NUM_WIN-1:0][MAP_W-1:0]  map_flat
);
   logic win_write;
   logic key_write;
   assign win_write = wr_en && (wr_sel[IDX_W+1:IDX_W] != KIND_LOCK);
   assign key_write = wr_en && (wr_sel[IDX_W+1:IDX_W] == KIND_LOCK) && (wr_data[15:0] == UNLOCK_KEY);

   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_addr == '0 && res_win == '0 && res_type == 3'b000 && res_cfg_lo == 2'b00)); // R6
   AST_LAST_IS_IO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit && 32'(res_win) == NUM_WIN - 1) |-> res_type == CYC_IO); // R7
   AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> 32'(res_win) < NUM_WIN); // R4
   AST_CFG_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_type != CYC_CFG) |-> res_cfg_lo == 2'b00); // R8
   AST_CFG_LO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_type == CYC_CFG) |-> res_cfg_lo == res_addr[1:0]); // R8
   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && win_write) |=> (base_flat == $past(base_flat) && map_flat == $past(map_flat))); // R9
   AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && key_write) |=> !locked); // R9
endmodule

bind addr_window_xlate awt_checker #(
   .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MAP_W(MAP_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .req_valid(req_valid), .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
   .res_addr(res_addr), .res_type(res_type), .res_cfg_lo(res_cfg_lo),
   .locked(lock_q), .base_flat(base_q), .map_flat(map_q)
);

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        res_valid, res_hit;
   logic [1:0]  res_win, res_cfg_lo;
   logic [31:0] res_addr;
   logic [2:0]  res_type;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_base [3];
   logic [15:0] m_map  [3];
   logic        m_lock;

   addr_window_xlate uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req_valid(req_valid), .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit),
      .res_win(res_win), .res_addr(res_addr), .res_type(res_type), .res_cfg_lo(res_cfg_lo)
   );

   always #5 clk = ~clk;

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // {hit, win[1:0], addr[31:0], type[2:0], cfg_lo[1:0]}
   function automatic logic [39:0] predict(input logic [31:0] a);
      longint unsigned sz, lo, off;
      int c;
      logic [2:0]  t;
      logic [31:0] x;
      for (int i = 0; i < 3; i++) begin
         if (m_base[i][0]) begin
            c = int'(m_base[i][4:1]);
            if (c > 11) c = 11;
            sz = 64'd1 << (20 + c);
            lo = {32'h0, m_base[i][31:20], 20'h0} & ~(sz - 1);
            if (64'(a) >= lo && 64'(a) < lo + sz) begin
               off = 64'(a) - lo;
               t = (i == 2) ? 3'b000 : m_map[i][3:1];
               x = {m_map[i][15:4], 20'h0} + off[31:0];
               if (t == 3'b101 && !m_map[i][0]) x[1:0] = 2'b00;
               return {1'b1, 2'(i), x, t, (t == 3'b101) ? x[1:0] : 2'b00};
            end
         end
      end
      return '0;
   endfunction

   function automatic void mwrite(input logic [3:0] sel, input logic [31:0] d);
      if (sel[3:2] == 2'd2) begin
         if (m_lock) begin
            if (d[15:0] == 16'hA05F) m_lock = 1'b0;
         end else if (d[14]) m_lock = 1'b1;
      end else if (!m_lock && sel[1:0] < 2'd3) begin
         if (sel[3:2] == 2'd0) m_base[sel[1:0]] = d;
         else if (sel[3:2] == 2'd1) m_map[sel[1:0]] = d[15:0];
      end
   endfunction

   task automatic wr(input logic [3:0] sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      mwrite(sel, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic req(input logic [31:0] a, input string tag);
      logic [39:0] exp;
      req_valid = 1'b1; req_addr = a;
      exp = predict(a);
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid && {res_hit, res_win, res_addr, res_type, res_cfg_lo} == exp, tag,
          {23'h0, res_valid, res_hit, res_win, res_addr, res_type, res_cfg_lo}, {23'h0, 1'b1, exp});
   endtask

   task automatic unlock();
      wr(4'b1000, 32'h0000_A05F);
   endtask

   task automatic relock();
      wr(4'b1000, 32'h0000_4000);
   endtask

   initial begin
      logic [39:0] old_exp;
      void'($urandom(32'd4711));
      for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_map[i] = '0; end
      m_lock = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == 1'b0, "R1 valid after reset", 64'(res_valid), 64'd0);
      req(32'h4000_0000, "R1 miss after reset");
      wr(4'b0000, 32'h4000_0011);          // locked: ignored
      req(32'h4000_0000, "R9 base write while locked ignored");
      wr(4'b1000, 32'h0000_1234);          // wrong key
      wr(4'b0000, 32'h4000_0011);
      req(32'h4000_0000, "R9 wrong key keeps lock");

      unlock();
      wr(4'b0000, 32'h4000_0011);          // 256 MB
      wr(4'b0100, 32'h0000_0006);          // map 0 -> memory
      wr(4'b0001, 32'h5000_0011);
      wr(4'b0101, 32'h0000_100C);          // map 1 -> 0x1000_0000, multiple memory
      wr(4'b0010, 32'h6000_0009);          // 16 MB
      wr(4'b0110, 32'h0000_000A);          // cfg type field, must read as I/O
      req(32'h4123_4567, "R5 window 0 memory translation");
      chk(res_addr == 32'h0123_4567, "R5 window 0 address", 64'(res_addr), 64'h0123_4567);
      req(32'h5000_0010, "R7 window 1 multiple memory");
      chk(res_type == 3'b110, "R7 window 1 type", 64'(res_type), 64'd6);
      req(32'h60AB_CDEF, "R7 last window forced I/O");
      chk(res_type == 3'b000, "R7 last window type", 64'(res_type), 64'd0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R2 no result without request", 64'(res_valid), 64'd0);
      req(32'h6100_0000, "R6 miss gives zeros");
      req(32'h4FFF_FFFF, "R3 last byte of window hits");
      req(32'h3FFF_FFFF, "R3 byte below window misses");
      wr(4'b0001, 32'h5000_0010);          // enable clear
      req(32'h5000_0010, "R3 disabled window never hits");

      // widen window 0 to 512 MB, window 1 as config aperture
      wr(4'b0000, 32'h4000_0013);
      wr(4'b0001, 32'h5000_0011);
      req(32'h5000_0010, "R4 lowest window wins overlap");
      chk(res_win == 2'd0, "R4 winner index", 64'(res_win), 64'd0);
      wr(4'b0001, 32'h6100_0009);          // 16 MB at 0x6100_0000
      wr(4'b0101, 32'h0000_000A);          // cfg, low bits forced
      req(32'h6100_0000 | (32'd1 << 14) | (32'd1 << 8) | 32'h13, "R11 type 0 slot 3");
      chk(res_addr == 32'h0000_4110 && res_cfg_lo == 2'b00, "R8 type 0 low bits forced",
          64'(res_addr), 64'h4110);
      wr(4'b0101, 32'h0000_040A);          // slot 15 via map bit 10 -> A26
      req(32'h6100_0000 | (32'd2 << 8) | 32'h04, "R11 type 0 slot above 12");
      chk(res_addr == 32'h0400_0204, "R11 high device select", 64'(res_addr), 64'h0400_0204);
      wr(4'b0101, 32'h0000_000B);          // cfg, low bits passed
      req(32'h6100_0000 | (32'd5 << 16) | (32'd2 << 11) | (32'd3 << 8) | 32'h09, "R11 type 1 fields");
      chk(res_addr == 32'h0005_1309 && res_cfg_lo == 2'b01, "R8 type 1 low bits passed",
          {30'h0, res_cfg_lo, res_addr}, {30'h0, 2'b01, 32'h0005_1309});
      req(32'h4400_0003, "R8 memory cycle low bits untouched");
      chk(res_addr[1:0] == 2'b11 && res_cfg_lo == 2'b00, "R8 non-config cfg_lo", 64'(res_cfg_lo), 64'd0);

      // same-cycle write and request
      wr_en = 1'b1; wr_sel = 4'b0000; wr_data = 32'h4000_0010;
      req_valid = 1'b1; req_addr = 32'h4800_0000;
      old_exp = predict(32'h4800_0000);
      mwrite(4'b0000, 32'h4000_0010);
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      chk({res_hit, res_win, res_addr, res_type, res_cfg_lo} == old_exp, "R10 same-cycle uses old",
          64'({res_hit, res_win, res_addr, res_type, res_cfg_lo}), 64'(old_exp));
      req(32'h4800_0000, "R10 next request sees write");

      relock();
      wr(4'b0000, 32'h4000_0011);
      req(32'h4800_0000, "R9 relocked write ignored");
      unlock();
      wr(4'b0000, 32'h4000_0011);
      req(32'h4800_0000, "R9 unlocked write applies");

      // random phase
      for (int r = 0; r < 400; r++) begin
         if ($urandom_range(9) < 4) begin
            logic [1:0]  w;
            logic [3:0]  code;
            logic [11:0] b;
            logic [15:0] m;
            if ($urandom_range(3) == 0) unlock();
            w = 2'($urandom_range(2));
            case ($urandom_range(3))
               0: code = 4'd4;
               1: code = 4'd8;
               2: code = 4'd9;
               default: code = 4'($urandom);
            endcase
            case ($urandom_range(3))
               0: b = 12'h400;
               1: b = 12'h480;
               2: b = 12'h500;
               default: b = 12'($urandom);
            endcase
            m = 16'($urandom);
            case ($urandom_range(3))
               0: m[3:1] = 3'b011;
               1: m[3:1] = 3'b110;
               2: m[3:1] = 3'b101;
               default: ;
            endcase
            wr({2'b00, w}, {b, 15'($urandom), code, ($urandom_range(4) != 0)});
            wr({2'b01, w}, {16'($urandom), m});
            if ($urandom_range(3) == 0) relock();
            if ($urandom_range(4) == 0) wr(4'($urandom), $urandom);
         end
         for (int k = 0; k < 5; k++) begin
            logic [31:0] a;
            int i, c;
            i = $urandom_range(2);
            c = int'(m_base[i][4:1]);
            if (c > 11) c = 11;
            if ($urandom_range(4) == 0) a = $urandom;
            else a = {m_base[i][31:20], 20'h0} ^ ($urandom & ((32'd1 << (21 + c)) - 1));
            req(a, "R3 R4 R5 R7 R8 random translation");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule